// File: doc/BRIEF.md
# Keypad Scanner with Multiplexed Digit Display

This block time-shares one set of strobe lines between a four-digit multiplexed numeric display and a 4-row by 3-column key matrix. Every scan slot belongs to one row index. In that slot the block puts out that index's stored display digit and drives the matching row line. After a programmable settle time it reads the three column lines. The stored digits are loaded through a small write port: an enable, a digit index and a value.

Each row has its own debounce state, so a key must read the same for a run of consecutive samples before it is taken. A newly accepted pattern that has a key in it produces a single-cycle event carrying a 4-bit key code. Releasing a key updates the row state but produces no event. The display value goes out as a raw nibble together with a blank flag. Segment decoding is left to the consumer.

Top module: `keypad_display_scan`

## Requirements
- R1: The row lines are one-hot or all low. Successive active slots drive `row_o` = 4'b0001, 4'b0010, 4'b0100, 4'b1000 and then wrap back to 4'b0001.
- R2: Each slot begins with exactly two cycles in which `row_o` is all low. The display value is loaded from the digit store in the second of those cycles. The row then stays high for SETTLE_CYCLES+1 cycles and the columns are sampled in the last of them. `digit_o` does not change while a row is high.
- R3: A column sample equal to the row's last accepted pattern leaves that row's debounce state unchanged.
- R4: A sample that differs from both the last accepted pattern and the candidate becomes the new candidate and clears the 4-bit match counter. A sample equal to the candidate advances the counter. The pattern is accepted on the sample that wraps the counter to zero, which is the 17th sample of a steady press. A candidate left behind by a short press is kept, with its count, across samples that equal the last accepted pattern.
- R5: Key codes: row 0 gives 1, 2, 3; row 1 gives 4, 5, 6; row 2 gives 7, 8, 9; row 3 gives 4'hA (star), 0, 4'hB (hash). The first key of a row sits on `col_i[2]`, the second on `col_i[1]` and the third on `col_i[0]`.
- R6: When several columns of a row read high together, the highest column index decides the key.
- R7: A key event is a `key_valid_o` pulse exactly one cycle long. It appears in the cycle after the accepting sample, when `row_o` is already all low.
- R8: Accepting an all-zero pattern (a release) produces no key event.
- R9: `blank_o` is high exactly when the displayed digit value is above 9.
- R10: A write with `dig_we_i` high stores `dig_val_i` in digit `dig_sel_i`. Digit N is shown during the slot of row N, from the next load onward.
- R11: After reset all row lines are low, `key_valid_o` is low and `digit_o` is 0. Every stored digit and all debounce state are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dig_we_i | input | 1 | Digit store write enable |
| dig_sel_i | input | 2 | Index of the digit to write |
| dig_val_i | input | 4 | Digit value to write |
| col_i | input | 3 | Column sense lines of the key matrix |
| row_o | output | 4 | One-hot row drive and digit strobe |
| digit_o | output | 4 | Value of the digit now shown |
| blank_o | output | 1 | Current digit is above 9 and is shown blank |
| key_valid_o | output | 1 | One-cycle key event |
| key_code_o | output | 4 | Code of the key event |

## Verification
Every key is held for exactly 17 samples of its row. This shows whether acceptance comes on the counter wrap or one sample early or late, and it checks the full code map. Multi-column presses check the column priority. A 16-sample press followed by a single matching sample shows that a stale candidate keeps its count. A brief press of one key followed by a steady press of another in the same row checks that a differing sample restarts the count. Releases between presses must stay silent, and digit values on either side of 9 tell shown digits apart from blanked ones.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  typedef enum logic [1:0] {
    ST_CLEAR  = 2'd0,
    ST_LATCH  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_SAMPLE = 2'd3
  } scan_st_e;

  localparam logic [3:0] KEY_STAR = 4'hA;
  localparam logic [3:0] KEY_HASH = 4'hB;
endpackage

// File: rtl/kpd_scan_seq.sv
module kpd_scan_seq
  import kpd_pkg::*;
#(
  parameter int NUM_ROWS      = 4,
  parameter int SETTLE_CYCLES = 4,
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [ROW_W-1:0]    row_idx_o,
  output logic [NUM_ROWS-1:0] row_o,
  output logic                latch_o,
  output logic                smp_o
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

  scan_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_CLEAR;
      cnt_q <= '0;
      row_q <= '0;
    end else begin
      unique case (st_q)
        ST_CLEAR: st_q <= ST_LATCH;
        ST_LATCH: begin
          st_q  <= ST_SETTLE;
          cnt_q <= CNT_W'(SETTLE_CYCLES - 1);
        end
        ST_SETTLE: begin
          if (cnt_q == '0) st_q <= ST_SAMPLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_SAMPLE: begin
          st_q  <= ST_CLEAR;
          row_q <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
        end
        default: st_q <= ST_CLEAR;
      endcase
    end
  end

  logic drive;
  assign drive     = (st_q == ST_SETTLE) || (st_q == ST_SAMPLE);
  assign latch_o   = (st_q == ST_LATCH);
  assign smp_o     = (st_q == ST_SAMPLE);
  assign row_idx_o = row_q;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign row_o[r] = drive && (row_q == ROW_W'(r));
  end

  p_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_o));
  p_advance_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_o |=> (row_idx_o == (($past(row_idx_o) == LAST_ROW) ? '0 : $past(row_idx_o) + 1'b1)));
  p_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_o |=> (row_o == '0) ##1 (row_o == '0));
  p_latch_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> (row_o == '0));
  p_sample_driven_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_o |-> (row_o != '0) && $stable(row_o));
endmodule

// File: rtl/kpd_row_debounce.sv
module kpd_row_debounce #(
  parameter int NUM_COLS = 3,
  parameter int DB_W     = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_en_i,
  input  logic [NUM_COLS-1:0] smp_i,
  output logic                acc_o,
  output logic [NUM_COLS-1:0] acc_val_o
);
  logic [NUM_COLS-1:0] cand_q, last_q;
  logic [DB_W-1:0]     cnt_q;
  logic                hit_last, hit_cand;

  assign hit_last  = (smp_i == last_q);
  assign hit_cand  = (smp_i == cand_q);
  assign acc_o     = smp_en_i && !hit_last && hit_cand && (cnt_q == '1);
  assign acc_val_o = cand_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= '0;
      last_q <= '0;
      cnt_q  <= '0;
    end else if (smp_en_i && !hit_last) begin
      if (!hit_cand) begin
        cand_q <= smp_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;  // wrap to zero accepts
        if (cnt_q == '1) last_q <= cand_q;
      end
    end
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_en_i && hit_last) |=> $stable(cand_q) && $stable(cnt_q) && $stable(last_q));
  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_en_i && !hit_last && !hit_cand) |=> (cnt_q == '0) && (cand_q == $past(smp_i)));
  p_accept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |=> (last_q == $past(smp_i)) && (cnt_q == '0));
  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_en_i |=> $stable(cand_q) && $stable(cnt_q) && $stable(last_q));
endmodule

// File: rtl/kpd_key_encode.sv
module kpd_key_encode
  import kpd_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int NUM_COLS = 3,
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input  logic [ROW_W-1:0]    row_i,
  input  logic [NUM_COLS-1:0] cols_i,
  output logic [3:0]          code_o,
  output logic                hit_o
);
  int pos;

  always_comb begin
    hit_o = 1'b0;
    pos   = 0;
    // highest column wins
    for (int c = 0; c < NUM_COLS; c++) begin
      if (!hit_o && cols_i[NUM_COLS-1-c]) begin
        hit_o = 1'b1;
        pos   = c;
      end
    end
    if (row_i != ROW_W'(NUM_ROWS - 1)) begin
      code_o = 4'(int'(row_i) * NUM_COLS + pos + 1);
    end else begin
      unique case (pos)
        0:       code_o = KEY_STAR;
        1:       code_o = 4'h0;
        default: code_o = KEY_HASH;
      endcase
    end
  end
endmodule

// File: rtl/keypad_display_scan.sv
module keypad_display_scan
  import kpd_pkg::*;
#(
  parameter int NUM_ROWS      = 4,
  parameter int NUM_COLS      = 3,
  parameter int DIG_W         = 4,
  parameter int SETTLE_CYCLES = 4,
  parameter int DB_W          = 4,
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dig_we_i,
  input  logic [ROW_W-1:0]    dig_sel_i,
  input  logic [DIG_W-1:0]    dig_val_i,
  input  logic [NUM_COLS-1:0] col_i,
  output logic [NUM_ROWS-1:0] row_o,
  output logic [DIG_W-1:0]    digit_o,
  output logic                blank_o,
  output logic                key_valid_o,
  output logic [3:0]          key_code_o
);
  logic [ROW_W-1:0]    row_idx;
  logic                latch, smp;
  logic [DIG_W-1:0]    dig_q [NUM_ROWS];
  logic [DIG_W-1:0]    disp_q;
  logic [NUM_ROWS-1:0] acc;
  logic [NUM_COLS-1:0] acc_val [NUM_ROWS];
  logic                acc_any, hit;
  logic [3:0]          code;
  logic                kv_q;
  logic [3:0]          kc_q;

  kpd_scan_seq #(.NUM_ROWS(NUM_ROWS), .SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
    .clk_i, .rst_ni,
    .row_idx_o(row_idx), .row_o(row_o), .latch_o(latch), .smp_o(smp)
  );

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_db
    kpd_row_debounce #(.NUM_COLS(NUM_COLS), .DB_W(DB_W)) u_db (
      .clk_i, .rst_ni,
      .smp_en_i (smp && (row_idx == ROW_W'(r))),
      .smp_i    (col_i),
      .acc_o    (acc[r]),
      .acc_val_o(acc_val[r])
    );
  end

  assign acc_any = |acc;

  kpd_key_encode #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_enc (
    .row_i(row_idx), .cols_i(acc_val[row_idx]), .code_o(code), .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_ROWS; r++) dig_q[r] <= '0;
      disp_q <= '0;
      kv_q   <= 1'b0;
      kc_q   <= '0;
    end else begin
      if (dig_we_i) dig_q[dig_sel_i] <= dig_val_i;
      if (latch)    disp_q <= dig_q[row_idx];
      kv_q <= acc_any && hit;  // release gives no event
      if (acc_any && hit) kc_q <= code;
    end
  end

  assign digit_o     = disp_q;
  assign blank_o     = (disp_q > DIG_W'(9));
  assign key_valid_o = kv_q;
  assign key_code_o  = kc_q;

  p_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |=> !key_valid_o);
  p_event_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> (row_o == '0));
  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_any && (acc_val[row_idx] == '0)) |=> !key_valid_o);
  p_digit_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((row_o != '0) && ($past(row_o) != '0)) |-> $stable(digit_o));
  p_single_acc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(acc));
endmodule

// File: tb/keypad_display_scan_bench.sv
module keypad_display_scan_bench;
  localparam int SETTLE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dig_we = 1'b0;
  logic [1:0] dig_sel = '0;
  logic [3:0] dig_val = '0;
  logic [2:0] col;
  logic [3:0] row;
  logic [3:0] digit;
  logic       blank, key_valid;
  logic [3:0] key_code;

  int         prow = 0;
  logic [2:0] pcol = '0;
  assign col = row[prow] ? pcol : 3'b000;

  always #10 clk = ~clk;

  keypad_display_scan #(.SETTLE_CYCLES(SETTLE)) u_keypad_display_scan (
    .clk_i(clk), .rst_ni(rst_n), .dig_we_i(dig_we), .dig_sel_i(dig_sel),
    .dig_val_i(dig_val), .col_i(col), .row_o(row), .digit_o(digit),
    .blank_o(blank), .key_valid_o(key_valid), .key_code_o(key_code)
  );

  int n_chk = 0, n_bad = 0;
  logic [3:0] exp_q [$];
  logic [3:0] mdig [4];
  logic disp_chk = 1'b0;
  bit done = 1'b0;

  function automatic logic [3:0] key_of(int r, int p);
    if (r < 3) return 4'(r * 3 + p + 1);
    case (p)
      0: return 4'hA;
      1: return 4'h0;
      default: return 4'hB;
    endcase
  endfunction

  // drive col pattern for n windows of row r
  task automatic hold(input int r, input logic [2:0] c, input int n);
    wait (row[r] == 1'b0);
    prow = r;
    pcol = c;
    for (int i = 0; i < n; i++) begin
      @(posedge row[r]);
      @(negedge row[r]);
    end
    pcol = 3'b000;
  endtask

  task automatic press(input int r, input int p, input int n, input bit expect_ev);
    if (expect_ev) exp_q.push_back(key_of(r, p));
    hold(r, 3'(3'b100 >> p), n);
  endtask

  // scoreboard monitor and slot timing checks
  logic [3:0] prev_row = '0, exp_row = 4'b0001;
  logic [3:0] rise_digit = '0;
  int  gap = 0, width = 0, slots = 0;
  logic prev_kv = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (key_valid) begin
        n_chk++;
        if (prev_kv || row != 4'b0000) begin
          n_bad++;
          $display("FAIL R7 pulse shape prev_kv=%0b row=%b expected prev_kv=0 row=0000", prev_kv, row);
        end
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R8 unexpected event code=%h expected none", key_code);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          if (key_code != e) begin
            n_bad++;
            $display("FAIL R5 key code got=%h expected=%h", key_code, e);
          end
        end
      end
      prev_kv <= key_valid;
      if (row != 4'b0000 && prev_row == 4'b0000) begin
        n_chk++;
        if (row != exp_row) begin
          n_bad++;
          $display("FAIL R1 row got=%b expected=%b", row, exp_row);
        end
        if (slots > 0) begin
          n_chk++;
          if (gap != 2) begin
            n_bad++;
            $display("FAIL R2 low gap got=%0d expected=2", gap);
          end
        end
        if (disp_chk) begin
          n_chk++;
          if (digit != mdig[slots % 4] || blank != (mdig[slots % 4] > 4'd9)) begin
            n_bad++;
            $display("FAIL R10 R9 digit got=%h blank=%0b expected=%h blank=%0b",
                     digit, blank, mdig[slots % 4], mdig[slots % 4] > 4'd9);
          end
        end
        exp_row <= {exp_row[2:0], exp_row[3]};
        rise_digit <= digit;
        width <= 1;
        gap <= 0;
      end else if (row != 4'b0000) begin
        width <= width + 1;
        if (digit != rise_digit) begin
          n_chk++; n_bad++;
          $display("FAIL R2 digit moved got=%h expected=%h", digit, rise_digit);
        end
      end else begin
        gap <= gap + 1;
        if (prev_row != 4'b0000) begin
          slots <= slots + 1;
          n_chk++;
          if (width != SETTLE + 1) begin
            n_bad++;
            $display("FAIL R2 row width got=%0d expected=%0d", width, SETTLE + 1);
          end
        end
      end
      prev_row <= row;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog cycles=%0d expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mdig[i] = 4'h0;
    repeat (3) @(negedge clk);
    // R11 reset state
    n_chk++;
    if (row != 4'b0000 || key_valid || digit != 4'h0) begin
      n_bad++;
      $display("FAIL R11 reset row=%b kv=%0b digit=%h expected 0000 0 0", row, key_valid, digit);
    end
    rst_n = 1'b1;

    // R10/R9: digit store and blanking
    mdig[0] = 4'h3; mdig[1] = 4'h9; mdig[2] = 4'hA; mdig[3] = 4'hF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      dig_we = 1'b1; dig_sel = 2'(i); dig_val = mdig[i];
    end
    @(negedge clk);
    dig_we = 1'b0;
    wait (slots % 4 == 0);
    @(posedge row[3]);
    @(negedge row[3]);
    disp_chk = 1'b1;
    repeat (2) begin @(posedge row[3]); @(negedge row[3]); end
    disp_chk = 1'b0;

    // R5: every key, 17 samples each; R8: releases silent
    for (int r = 0; r < 4; r++) begin
      for (int p = 0; p < 3; p++) begin
        press(r, p, 17, 1'b1);
        hold(r, 3'b000, 20);
      end
    end

    // R6: multi-column priority
    exp_q.push_back(4'h1);
    hold(0, 3'b111, 17);
    hold(0, 3'b000, 20);
    exp_q.push_back(4'h2);
    hold(0, 3'b011, 17);
    hold(0, 3'b000, 20);
    exp_q.push_back(4'hB);
    hold(3, 3'b001, 17);
    hold(3, 3'b000, 20);

    // R4: 16 samples not enough; stale candidate keeps its count
    press(1, 1, 16, 1'b0);
    hold(1, 3'b000, 5);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R4 pending=%0d expected 0", exp_q.size());
    end
    press(1, 1, 1, 1'b1);   // 17th matching sample accepts
    hold(1, 3'b000, 20);

    // R4: differing sample restarts count
    press(2, 0, 10, 1'b0);
    press(2, 2, 17, 1'b1);
    hold(2, 3'b000, 20);

    repeat (20) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R4 R5 missing events=%0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule